// File: doc/BRIEF.md
# Multi-Stage Expiration Watchdog

This block is a watchdog timer that splits its full timeout into five equal stages. A single down counter is loaded with the stage length, which is one fifth of the timeout. A one-microsecond tick strobe advances it. When a stage runs out, the counter reloads at once and a three-bit expiration count goes up by one. The system reset output is raised only when the fifth stage runs out. A stalled supervisor therefore gets five full stage periods before the chip is reset. Software can read the count at any time and work out the time left.

Software sets it up through a small word-addressed register port. A configuration register holds the interrupt enable and the reset enable. A period register holds the stage length. A command register starts or disables the counter. Two status registers expose the expiration count, the live counter value and a sticky interrupt flag, which is cleared by writing a one to it. The ping input restarts the current run. Once the reset pulse ends, the block returns to the disabled state and waits for a new start command.

Top module: `multi_stage_wdt`

## Requirements
- R1: After rst_ni is released, the configuration register (0x00) reads 0, the expiration status (0x04) reads 0, the timer status (0x10) reads 0, the period register (0x0C) reads RESET_PERIOD, and both irq_o and sys_rst_o are low.
- R2: Writing bit 0 of the command register (0x08) loads the counter with the period and clears the expiration count. While running, each cycle with tick_i high lowers the counter (timer status bits 28:0) by one. A cycle without a tick leaves it unchanged.
- R3: A tick that finds the counter at 1 or below is an expiration. The counter reloads with the period and the expiration count (status 0x04 bits 14:12) rises by one. The count never exceeds 4.
- R4: With the reset enable (configuration bit 1) set, the fifth expiration raises sys_rst_o in the same clock edge. It stays high for exactly PULSE_CYC cycles, after which the block is disabled: ticks no longer move the counter.
- R5: With the reset enable clear, the fifth expiration gives no reset pulse. The block becomes disabled with the expiration count at 0.
- R6: Writing bit 1 of the command register disables the block. The count returns to 0 and the counter holds its value. If bits 0 and 1 are written together, the disable wins.
- R7: A ping while running reloads the counter with the period and clears the count, and the block stays running. A ping while disabled changes nothing.
- R8: With the interrupt enable (configuration bit 0) set, every expiration sets a sticky flag, seen on irq_o and at timer status bit 30. Writing 1 to bit 30 of 0x10 clears it. If an expiration and the clear fall in the same cycle, the flag is set.
- R9: While the reset pulse is high, start, disable and ping are all ignored. The pulse keeps its full length and the block ends up disabled.
- R10: The period register keeps bits 28:0 of the written word. A period of 0 acts as a stage of one tick.
- R11: The configuration register reads back bits 1:0 as written. The command register always reads 0, and writes to the expiration status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond tick strobe |
| ping_i | input | 1 | Restart of the current run |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read byte address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Sticky expiration interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest case to reach is the fifth expiration while other events are in flight. Examples are an interrupt clear that lands on the same tick as an expiration, or a start, disable or ping that arrives while the reset pulse is running. Directed sequences set a short stage period and count ticks exactly, so that these collisions fall on chosen cycles. A long seeded random phase then mixes short periods, frequent ticks, rare pings and random writes. This drives the block through many complete five-stage runs, and a bench model tracks every register after each cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CFG    = 5'h00;
  localparam logic [ADDR_W-1:0] A_WSTAT  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CMD    = 5'h08;
  localparam logic [ADDR_W-1:0] A_PERIOD = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TSTAT  = 5'h10;

  localparam int unsigned EXP_LSB    = 12;
  localparam int unsigned IRQ_BIT    = 30;
  localparam int unsigned START_BIT  = 0;
  localparam int unsigned STOP_BIT   = 1;
  localparam int unsigned IRQ_EN_BIT = 0;
  localparam int unsigned RST_EN_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIRE = 2'd2
  } wdt_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 29,
  parameter int unsigned EXP_W        = 3,
  parameter int unsigned RESET_PERIOD = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_pend_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              irq_clr_o,
  output logic              irq_en_o,
  output logic              rst_en_o,
  output logic [CNT_W-1:0]  period_o
);
  logic              wr_cfg, wr_cmd, wr_per, wr_tst;
  logic              irq_en_q, rst_en_q;
  logic [CNT_W-1:0]  period_q;
  logic              data_unused;

  assign wr_cfg = wr_en_i && (wr_addr_i == A_CFG);
  assign wr_cmd = wr_en_i && (wr_addr_i == A_CMD);
  assign wr_per = wr_en_i && (wr_addr_i == A_PERIOD);
  assign wr_tst = wr_en_i && (wr_addr_i == A_TSTAT);

  assign start_o   = wr_cmd && wr_data_i[START_BIT];
  assign stop_o    = wr_cmd && wr_data_i[STOP_BIT];
  assign irq_clr_o = wr_tst && wr_data_i[IRQ_BIT];
  assign data_unused = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      period_q <= CNT_W'(RESET_PERIOD);
    end else begin
      if (wr_cfg) begin
        irq_en_q <= wr_data_i[IRQ_EN_BIT];
        rst_en_q <= wr_data_i[RST_EN_BIT];
      end
      if (wr_per) period_q <= wr_data_i[CNT_W-1:0];
    end
  end

  assign irq_en_o = irq_en_q;
  assign rst_en_o = rst_en_q;
  assign period_o = period_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CFG: begin
        rd_data_o[IRQ_EN_BIT] = irq_en_q;
        rd_data_o[RST_EN_BIT] = rst_en_q;
      end
      A_WSTAT:  rd_data_o[EXP_LSB +: EXP_W] = exp_i;
      A_PERIOD: rd_data_o[CNT_W-1:0] = period_q;
      A_TSTAT: begin
        rd_data_o[CNT_W-1:0] = cnt_i;
        rd_data_o[IRQ_BIT]   = irq_pend_i;
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned STAGES = 5,
  parameter int unsigned EXP_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             expire_o,
  output logic             last_o
);
  localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(STAGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;

  // stage ends on the tick that would bring the counter to zero
  assign expire_o = run_i && tick_i && !clr_i && !load_i && (cnt_q <= CNT_W'(1));
  assign last_o   = expire_o && (exp_q == EXP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (clr_i) begin
      exp_q <= '0;
    end else if (load_i) begin
      cnt_q <= period_i;
      exp_q <= '0;
    end else if (expire_o) begin
      cnt_q <= period_i;
      exp_q <= last_o ? '0 : exp_q + EXP_W'(1);
    end else if (run_i && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/wdt_fire.sv
module wdt_fire
  import wdt_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic last_i,
  input  logic expire_i,
  input  logic rst_en_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic run_o,
  output logic fire_o,
  output logic sys_rst_o,
  output logic irq_o
);
  wdt_state_e state_q, state_d;
  logic       pulse_done, enter_fire;
  logic       rst_q, irq_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i && !stop_i) state_d = ST_RUN;
      ST_RUN: begin
        if (stop_i)      state_d = ST_IDLE;
        else if (last_i) state_d = rst_en_i ? ST_FIRE : ST_IDLE;
      end
      ST_FIRE: if (pulse_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_fire = (state_q != ST_FIRE) && (state_d == ST_FIRE);

  if (PULSE_CYC > 1) begin : g_pulse_cnt
    localparam int unsigned PW = $clog2(PULSE_CYC);
    logic [PW-1:0] pcnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    pcnt_q <= '0;
      else if (enter_fire)                            pcnt_q <= PW'(PULSE_CYC - 1);
      else if (state_q == ST_FIRE && pcnt_q != '0)    pcnt_q <= pcnt_q - PW'(1);
    end
    assign pulse_done = (pcnt_q == '0);
  end else begin : g_pulse_one
    assign pulse_done = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rst_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= (state_d == ST_FIRE);
      if (expire_i && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)       irq_q <= 1'b0;
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign fire_o    = (state_q == ST_FIRE);
  assign sys_rst_o = rst_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/multi_stage_wdt.sv
module multi_stage_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 29,
  parameter int unsigned STAGES       = 5,
  parameter int unsigned PULSE_CYC    = 16,
  parameter int unsigned RESET_PERIOD = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ping_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int unsigned EXP_W = $clog2(STAGES);

  logic             start, stop, irq_clr, irq_en, rst_en;
  logic [CNT_W-1:0] period, cnt;
  logic [EXP_W-1:0] exp_cnt;
  logic             run, fire, load, clr, expire, last;

  assign clr  = stop && !fire;
  assign load = !fire && !stop && (start || (ping_i && run));

  wdt_regs #(
    .CNT_W(CNT_W), .EXP_W(EXP_W), .RESET_PERIOD(RESET_PERIOD)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .exp_i(exp_cnt), .cnt_i(cnt), .irq_pend_i(irq_o),
    .start_o(start), .stop_o(stop), .irq_clr_o(irq_clr),
    .irq_en_o(irq_en), .rst_en_o(rst_en), .period_o(period)
  );

  wdt_stage_ctr #(
    .CNT_W(CNT_W), .STAGES(STAGES), .EXP_W(EXP_W)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(clr), .load_i(load), .run_i(run), .tick_i(tick_i),
    .period_i(period), .cnt_o(cnt), .exp_o(exp_cnt),
    .expire_o(expire), .last_o(last)
  );

  wdt_fire #(
    .PULSE_CYC(PULSE_CYC)
  ) u_fire (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start), .stop_i(stop), .last_i(last), .expire_i(expire),
    .rst_en_i(rst_en), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .run_o(run), .fire_o(fire), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned STAGES = 5,
  parameter int unsigned EXP_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sys_rst_o,
  input logic             irq_o,
  input logic             run,
  input logic             fire,
  input logic             load,
  input logic             expire,
  input logic             irq_en,
  input logic             rst_en,
  input logic [EXP_W-1:0] exp_cnt,
  input logic [CNT_W-1:0] cnt
);
  p_exp_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_cnt <= EXP_W'(STAGES - 1));

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load) |=> $stable(cnt));

  p_rst_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(rst_en) && ($past(exp_cnt) == EXP_W'(STAGES - 1))));

  p_rst_ends_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (!run && !fire));

  p_idle_exp_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run) |-> (exp_cnt == '0));

  p_rst_not_running_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !run);

  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && irq_en) |=> irq_o);
endmodule

bind multi_stage_wdt wdt_chk #(
  .CNT_W(CNT_W), .STAGES(STAGES), .EXP_W(EXP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .sys_rst_o(sys_rst_o), .irq_o(irq_o),
  .run(run), .fire(fire), .load(load), .expire(expire),
  .irq_en(irq_en), .rst_en(rst_en), .exp_cnt(exp_cnt), .cnt(cnt)
);

// File: tb/multi_stage_wdt_bench.sv
module multi_stage_wdt_bench;
  import wdt_pkg::*;

  localparam int CNT_W   = 29;
  localparam int PULSE   = 16;
  localparam int RST_PER = 1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, ping_i = 1'b0, wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, sys_rst_o;

  always #10 clk = ~clk;

  multi_stage_wdt u_multi_stage_wdt (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ping_i(ping_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  bit             m_run = 0, m_fire = 0, m_irq = 0, m_rst = 0;
  bit             m_irq_en = 0, m_rst_en = 0;
  int             m_pcnt = 0;
  logic [CNT_W-1:0] m_cnt = '0, m_per = CNT_W'(RST_PER);
  logic [2:0]     m_exp = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic compare_all();
    logic [31:0] v;
    rd(A_TSTAT, v);
    chk("R2/R8 timer status", v, (32'(m_irq) << IRQ_BIT) | 32'(m_cnt));
    rd(A_WSTAT, v);
    chk("R3 expiration count", v, 32'(m_exp) << EXP_LSB);
    chk("R4 sys_rst_o", 32'(sys_rst_o), 32'(m_rst));
    chk("R8 irq_o", 32'(irq_o), 32'(m_irq));
  endtask

  // caller is at a negedge; drives one cycle, updates model, compares
  task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] d,
                      input bit tk, input bit pg);
    bit st, sp, ic, ev;
    bit n_run, n_fire, n_irq, n_rst, n_ie, n_re;
    int n_pcnt;
    logic [CNT_W-1:0] n_cnt, n_per;
    logic [2:0] n_exp;
    wr_en_i = wr; wr_addr_i = a; wr_data_i = d; tick_i = tk; ping_i = pg;
    st = wr && a == A_CMD && d[START_BIT];
    sp = wr && a == A_CMD && d[STOP_BIT];
    ic = wr && a == A_TSTAT && d[IRQ_BIT];
    n_run = m_run; n_fire = m_fire; n_irq = m_irq; n_rst = m_rst;
    n_ie = m_irq_en; n_re = m_rst_en; n_pcnt = m_pcnt;
    n_cnt = m_cnt; n_per = m_per; n_exp = m_exp; ev = 0;
    if (wr && a == A_CFG) begin n_ie = d[IRQ_EN_BIT]; n_re = d[RST_EN_BIT]; end
    if (wr && a == A_PERIOD) n_per = d[CNT_W-1:0];
    if (m_fire) begin
      if (m_pcnt == 0) begin n_fire = 0; n_rst = 0; end
      else n_pcnt = m_pcnt - 1;
    end else if (sp) begin
      n_run = 0; n_exp = 0;
    end else if (st) begin
      n_run = 1; n_cnt = m_per; n_exp = 0;
    end else if (m_run && pg) begin
      n_cnt = m_per; n_exp = 0;
    end else if (m_run && tk) begin
      if (m_cnt <= 1) begin
        ev = 1; n_cnt = m_per;
        if (m_exp == 4) begin
          n_exp = 0; n_run = 0;
          if (m_rst_en) begin n_fire = 1; n_rst = 1; n_pcnt = PULSE - 1; end
        end else n_exp = m_exp + 1;
      end else n_cnt = m_cnt - 1;
    end
    if (ev && m_irq_en) n_irq = 1;
    else if (ic) n_irq = 0;
    @(posedge clk);
    m_run = n_run; m_fire = n_fire; m_irq = n_irq; m_rst = n_rst;
    m_irq_en = n_ie; m_rst_en = n_re; m_pcnt = n_pcnt;
    m_cnt = n_cnt; m_per = n_per; m_exp = n_exp;
    @(negedge clk);
    wr_en_i = 0; tick_i = 0; ping_i = 0; wr_data_i = '0;
    compare_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d); step(1, a, d, 0, 0); endtask
  task automatic tk(); step(0, 5'h0, 32'h0, 1, 0); endtask
  task automatic idle(); step(0, 5'h0, 32'h0, 0, 0); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tk(); endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] v);
    return v & ((32'h1 << CNT_W) - 1);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_CFG, v);    chk("R1 cfg", v, 0);
    rd(A_WSTAT, v);  chk("R1 wstat", v, 0);
    rd(A_TSTAT, v);  chk("R1 tstat", v, 0);
    rd(A_PERIOD, v); chk("R1 period", v, RST_PER);
    chk("R1 outputs", {30'b0, irq_o, sys_rst_o}, 0);

    // R10 / R11 register map
    wr(A_PERIOD, 32'hE000_0003);
    rd(A_PERIOD, v); chk("R10 period keeps low bits", v, 3);
    wr(A_CFG, 32'h3);
    rd(A_CFG, v);    chk("R11 cfg readback", v, 3);
    rd(A_CMD, v);    chk("R11 cmd reads zero", v, 0);
    wr(A_WSTAT, 32'hFFFF_FFFF);
    rd(A_WSTAT, v);  chk("R11 wstat write ignored", v, 0);

    // R2 start and tick counting
    wr(A_CMD, 32'h1);
    rd(A_TSTAT, v);  chk("R2 loaded", cnt_of(v), 3);
    tk();
    rd(A_TSTAT, v);  chk("R2 one tick", cnt_of(v), 2);
    idle(); idle(); idle();
    rd(A_TSTAT, v);  chk("R2 no tick holds", cnt_of(v), 2);

    // R3 expiration reloads and counts
    tk(); tk();
    rd(A_TSTAT, v);  chk("R3 reload", cnt_of(v), 3);
    rd(A_WSTAT, v);  chk("R3 count one", v, 32'h1000);

    // R4 fifth expiration fires reset
    ticks(11);
    chk("R4 no reset before fifth", 32'(sys_rst_o), 0);
    tk();
    chk("R4 reset on fifth", 32'(sys_rst_o), 1);
    chk("R8 irq on expiration", 32'(irq_o), 1);
    hi = 1;
    for (int i = 0; i < PULSE + 4; i++) begin idle(); if (sys_rst_o) hi++; end
    chk("R4 pulse length", hi, PULSE);
    ticks(3);
    rd(A_TSTAT, v);  chk("R4 disabled after pulse", cnt_of(v), 3);

    // R8 clear, then set wins over clear
    wr(A_TSTAT, 32'h4000_0000);
    chk("R8 cleared", 32'(irq_o), 0);
    wr(A_CMD, 32'h1);
    tk(); tk();
    step(1, A_TSTAT, 32'h4000_0000, 1, 0);
    chk("R8 set wins over clear", 32'(irq_o), 1);

    // R5 no reset enable
    wr(A_CMD, 32'h2);
    wr(A_CFG, 32'h1);
    wr(A_CMD, 32'h1);
    hi = 0;
    for (int i = 0; i < 15; i++) begin tk(); if (sys_rst_o) hi++; end
    chk("R5 no pulse", hi, 0);
    rd(A_WSTAT, v);  chk("R5 count zero", v, 0);
    tk();
    rd(A_TSTAT, v);  chk("R5 stopped", cnt_of(v), 3);

    // R6 disable mid-run, and disable beats start
    wr(A_CMD, 32'h1);
    ticks(4);
    wr(A_CMD, 32'h2);
    rd(A_WSTAT, v);  chk("R6 count cleared", v, 0);
    tk();
    rd(A_TSTAT, v);  chk("R6 counter holds", cnt_of(v), 2);
    wr(A_CMD, 32'h3);
    tk();
    rd(A_TSTAT, v);  chk("R6 disable wins", cnt_of(v), 2);

    // R7 ping running and idle
    wr(A_CMD, 32'h1);
    ticks(4);
    step(0, 5'h0, 32'h0, 1, 1);
    rd(A_TSTAT, v);  chk("R7 ping reloads", cnt_of(v), 3);
    rd(A_WSTAT, v);  chk("R7 ping clears count", v, 0);
    tk();
    rd(A_TSTAT, v);  chk("R7 still running", cnt_of(v), 2);
    wr(A_CMD, 32'h2);
    step(0, 5'h0, 32'h0, 0, 1);
    rd(A_TSTAT, v);  chk("R7 idle ping no effect", cnt_of(v), 2);

    // R9 commands during the pulse
    wr(A_CFG, 32'h2);
    wr(A_CMD, 32'h1);
    ticks(15);
    chk("R9 pulse up", 32'(sys_rst_o), 1);
    hi = 1;
    wr(A_CMD, 32'h2); if (sys_rst_o) hi++;
    wr(A_CMD, 32'h1); if (sys_rst_o) hi++;
    step(0, 5'h0, 32'h0, 1, 1); if (sys_rst_o) hi++;
    for (int i = 0; i < PULSE; i++) begin idle(); if (sys_rst_o) hi++; end
    chk("R9 pulse not cut", hi, PULSE);
    tk();
    rd(A_TSTAT, v);  chk("R9 ends disabled", cnt_of(v), 3);

    // R10 zero period is a one-tick stage
    wr(A_CFG, 32'h0);
    wr(A_PERIOD, 32'h0);
    wr(A_CMD, 32'h1);
    tk();
    rd(A_WSTAT, v);  chk("R10 zero period one tick", v, 32'h1000);
    tk();
    rd(A_WSTAT, v);  chk("R10 zero period second", v, 32'h2000);

    // seeded random mix against the model
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [4:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 99);
      if (op < 10) begin
        case ($urandom_range(0, 4))
          0: begin a = A_CFG;    d = $urandom_range(0, 3); end
          1: begin a = A_PERIOD; d = $urandom_range(0, 5); end
          2: begin a = A_CMD;    d = ($urandom_range(0, 9) < 8) ? 32'h1 : 32'($urandom_range(0, 3)); end
          3: begin a = A_TSTAT;  d = 32'h4000_0000; end
          default: begin a = A_WSTAT; d = $urandom; end
        endcase
        step(1, a, d, $urandom_range(0, 1) == 1, 1'b0);
      end else begin
        step(0, 5'h0, 32'h0, $urandom_range(0, 9) < 6, $urandom_range(0, 99) < 2);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule